// File: doc/BRIEF.md
# Register-Mapped Inter-Core Channel Fabric

This block ties a team of simple cores together so that chosen architectural registers act as one-word, point-to-point blocking channels. Each core owns a small mapping table. An entry binds one of the core's register numbers, in one direction, to a shared channel. When a core writes a register that is mapped as a channel source, the word goes into the channel. When a core reads a register that is mapped as a channel sink, the word is taken out of the channel. Source and sink may use different register numbers in different cores, for example register 12 of core 7 feeding register 10 of core 2.

Each channel holds one word and a full flag. A read of an empty channel stalls the reader. A write to a full channel stalls the writer, unless a read drains the channel in the same cycle. Registers that are not mapped are private: the fabric reports no hit and no stall for them, and the core uses its own register file. Stall outputs are combinational from the requests and the channel state. An accepted word becomes readable one cycle after the write. When several cores contend for one channel in the same cycle, the lowest-numbered core wins.

Mapping entries are loaded through a configuration write port, one entry per cycle.

Top module: `regch_fabric`

## Requirements
- R1: A read request whose register is mapped as a sink (rd_hit=1) on a full channel does not stall. rd_data carries the stored word, and the channel is empty from the next cycle on.
- R2: A sink read on an empty channel raises rd_stall for that core. It keeps stalling until a write has been accepted on that channel in an earlier cycle.
- R3: A source write on a full channel stalls when no read is accepted on that channel in the same cycle. The stored word is left unchanged.
- R4: A request for a register that has no matching valid entry gives hit=0 and stall=0 on that side, and rd_data=0. Every request gets rd_data=0 unless it is a read that is accepted from a channel.
- R5: On a full channel, an accepted read and a write in the same cycle both proceed. The reader gets the old word and the channel stays full with the new word.
- R6: A configuration write with cfg_valid=1 and cfg_reg=0 is ignored and the addressed entry keeps its previous contents. Register 0 therefore never hits.
- R7: A write accepted on an empty channel is not visible to a reader in the same cycle. It can be read from the next cycle on.
- R8: When several cores write, or read, the same channel in one cycle, only the lowest-numbered core can be accepted. The others stall.
- R9: A lookup only matches entries whose direction equals the access: cfg_dir=1 means the core writes into the channel and cfg_dir=0 means the core reads from it. When several entries match, the lowest slot number wins. A configuration write with cfg_valid=0 invalidates the entry.
- R10: After reset, every channel is empty and every mapping entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mapping entry write strobe |
| cfg_core | input | $clog2(NUM_CORES) | Core whose table is written |
| cfg_slot | input | $clog2(MAP_DEPTH) | Entry slot in that table |
| cfg_valid | input | 1 | Entry valid bit |
| cfg_dir | input | 1 | 1 = source (write side), 0 = sink (read side) |
| cfg_reg | input | 5 | Register number bound by the entry |
| cfg_chan | input | $clog2(NUM_CHAN) | Channel index bound by the entry |
| rd_req | input | NUM_CORES | Per-core register read request |
| rd_reg | input | 5*NUM_CORES | Per-core read register number |
| rd_hit | output | NUM_CORES | Read targets a channel |
| rd_stall | output | NUM_CORES | Read must wait |
| rd_data | output | DATA_W*NUM_CORES | Word delivered to an accepted read |
| wr_req | input | NUM_CORES | Per-core register write request |
| wr_reg | input | 5*NUM_CORES | Per-core write register number |
| wr_data | input | DATA_W*NUM_CORES | Per-core write word |
| wr_hit | output | NUM_CORES | Write targets a channel |
| wr_stall | output | NUM_CORES | Write must wait |

## Verification
The delicate case is a drain and a refill of one channel in the same cycle. A full channel sees an accepted read and a new write together, and the write is let through only because the read empties the slot. The bench provokes this directly on a full channel and also lets it arise under random traffic. It judges the result by checking that neither side stalls, that the reader gets the old word, and that the next read returns the new one. A second overlap, a write landing on an empty channel while its reader waits, is checked to keep the reader stalled in that cycle and release it the cycle after.

// File: rtl/regch_pkg.sv
package regch_pkg;

    // Architectural register number width of the attached cores
    localparam int unsigned REG_NUM_W = 5;

    // Direction of a mapping entry
    typedef enum logic {
        DIR_SINK   = 1'b0,  // core reads the channel
        DIR_SOURCE = 1'b1   // core writes the channel
    } chan_dir_e;

endpackage

// File: rtl/regch_map_table.sv
module regch_map_table
    import regch_pkg::*;
#(
    parameter int unsigned MAP_DEPTH = 4,
    parameter int unsigned CHAN_W    = 4,
    parameter int unsigned SLOT_W    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SLOT_W-1:0]             cfg_slot,
    input  logic                          cfg_valid,
    input  logic                          cfg_dir,
    input  logic [REG_NUM_W-1:0]          cfg_reg,
    input  logic [CHAN_W-1:0]             cfg_chan,
    output logic [MAP_DEPTH-1:0]          ent_valid,
    output logic [MAP_DEPTH-1:0]          ent_dir,
    output logic [MAP_DEPTH*REG_NUM_W-1:0] ent_reg,
    output logic [MAP_DEPTH*CHAN_W-1:0]   ent_chan
);

    typedef struct packed {
        logic                 valid;
        chan_dir_e            dir;
        logic [REG_NUM_W-1:0] rnum;
        logic [CHAN_W-1:0]    chan;
    } entry_t;

    entry_t [MAP_DEPTH-1:0] tab_d, tab_q;

    // Register 0 is never bound to a channel: such writes are dropped
    logic cfg_blocked;

    always_comb begin
        tab_d       = tab_q;
        cfg_blocked = cfg_valid && (cfg_reg == '0);
        if (cfg_we && !cfg_blocked) begin
            tab_d[cfg_slot].valid = cfg_valid;
            tab_d[cfg_slot].dir   = chan_dir_e'(cfg_dir);
            tab_d[cfg_slot].rnum  = cfg_reg;
            tab_d[cfg_slot].chan  = cfg_chan;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    for (genvar s = 0; s < MAP_DEPTH; s++) begin : g_out
        assign ent_valid[s]                         = tab_q[s].valid;
        assign ent_dir[s]                           = tab_q[s].dir;
        assign ent_reg[s*REG_NUM_W +: REG_NUM_W]    = tab_q[s].rnum;
        assign ent_chan[s*CHAN_W +: CHAN_W]         = tab_q[s].chan;
    end

endmodule

// File: rtl/regch_lookup.sv
module regch_lookup
    import regch_pkg::*;
#(
    parameter int unsigned MAP_DEPTH = 4,
    parameter int unsigned CHAN_W    = 4,
    parameter logic        WANT_DIR  = 1'b0
) (
    input  logic [MAP_DEPTH-1:0]           ent_valid,
    input  logic [MAP_DEPTH-1:0]           ent_dir,
    input  logic [MAP_DEPTH*REG_NUM_W-1:0] ent_reg,
    input  logic [MAP_DEPTH*CHAN_W-1:0]    ent_chan,
    input  logic                           req,
    input  logic [REG_NUM_W-1:0]           rnum,
    output logic                           hit,
    output logic [CHAN_W-1:0]              chan
);

    // Scan from the top slot down so the lowest matching slot is kept
    always_comb begin
        hit  = 1'b0;
        chan = '0;
        for (int s = MAP_DEPTH - 1; s >= 0; s--) begin
            if (ent_valid[s] && (ent_dir[s] == WANT_DIR) &&
                (ent_reg[s*REG_NUM_W +: REG_NUM_W] == rnum)) begin
                hit  = req;
                chan = ent_chan[s*CHAN_W +: CHAN_W];
            end
        end
    end

endmodule

// File: rtl/regch_chan_bank.sv
module regch_chan_bank #(
    parameter int unsigned NUM_CORES = 8,
    parameter int unsigned NUM_CHAN  = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CHAN_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          rd_hit,
    input  logic [NUM_CORES*CHAN_W-1:0]   rd_chan,
    input  logic [NUM_CORES-1:0]          wr_hit,
    input  logic [NUM_CORES*CHAN_W-1:0]   wr_chan,
    input  logic [NUM_CORES*DATA_W-1:0]   wr_data,
    output logic [NUM_CORES-1:0]          rd_ok,
    output logic [NUM_CORES*DATA_W-1:0]   rd_word,
    output logic [NUM_CORES-1:0]          wr_ok,
    output logic [NUM_CHAN-1:0]           chan_full
);

    typedef struct packed {
        logic [NUM_CHAN-1:0]             full;
        logic [NUM_CHAN-1:0][DATA_W-1:0] data;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [NUM_CHAN-1:0][NUM_CORES-1:0] rd_cand, wr_cand, rd_gnt, wr_gnt;
    logic [NUM_CHAN-1:0]                rd_acc, wr_acc;

    // Candidates per channel and lowest-index grant
    always_comb begin
        for (int c = 0; c < NUM_CHAN; c++) begin
            for (int i = 0; i < NUM_CORES; i++) begin
                rd_cand[c][i] = rd_hit[i] && (rd_chan[i*CHAN_W +: CHAN_W] == CHAN_W'(c));
                wr_cand[c][i] = wr_hit[i] && (wr_chan[i*CHAN_W +: CHAN_W] == CHAN_W'(c));
            end
            rd_gnt[c] = rd_cand[c] & (~rd_cand[c] + NUM_CORES'(1));
            wr_gnt[c] = wr_cand[c] & (~wr_cand[c] + NUM_CORES'(1));
            rd_acc[c] = (|rd_cand[c]) && bank_q.full[c];
            wr_acc[c] = (|wr_cand[c]) && (!bank_q.full[c] || rd_acc[c]);
        end
    end

    // Per-core acceptance and delivered word
    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) begin
            rd_ok[i] = rd_hit[i]
                     && rd_gnt[rd_chan[i*CHAN_W +: CHAN_W]][i]
                     && rd_acc[rd_chan[i*CHAN_W +: CHAN_W]];
            wr_ok[i] = wr_hit[i]
                     && wr_gnt[wr_chan[i*CHAN_W +: CHAN_W]][i]
                     && wr_acc[wr_chan[i*CHAN_W +: CHAN_W]];
            rd_word[i*DATA_W +: DATA_W] = rd_ok[i]
                     ? bank_q.data[rd_chan[i*CHAN_W +: CHAN_W]] : '0;
        end
    end

    // Next channel state
    always_comb begin
        bank_d = bank_q;
        for (int c = 0; c < NUM_CHAN; c++) begin
            if (wr_acc[c]) begin
                bank_d.full[c] = 1'b1;
                for (int i = 0; i < NUM_CORES; i++) begin
                    if (wr_gnt[c][i]) begin
                        bank_d.data[c] = wr_data[i*DATA_W +: DATA_W];
                    end
                end
            end else if (rd_acc[c]) begin
                bank_d.full[c] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign chan_full = bank_q.full;

endmodule

// File: rtl/regch_fabric.sv
module regch_fabric
    import regch_pkg::*;
#(
    parameter int unsigned NUM_CORES = 8,
    parameter int unsigned NUM_CHAN  = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned MAP_DEPTH = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [$clog2(NUM_CORES)-1:0]       cfg_core,
    input  logic [$clog2(MAP_DEPTH)-1:0]       cfg_slot,
    input  logic                               cfg_valid,
    input  logic                               cfg_dir,
    input  logic [4:0]                         cfg_reg,
    input  logic [$clog2(NUM_CHAN)-1:0]        cfg_chan,
    input  logic [NUM_CORES-1:0]               rd_req,
    input  logic [NUM_CORES*5-1:0]             rd_reg,
    output logic [NUM_CORES-1:0]               rd_hit,
    output logic [NUM_CORES-1:0]               rd_stall,
    output logic [NUM_CORES*DATA_W-1:0]        rd_data,
    input  logic [NUM_CORES-1:0]               wr_req,
    input  logic [NUM_CORES*5-1:0]             wr_reg,
    input  logic [NUM_CORES*DATA_W-1:0]        wr_data,
    output logic [NUM_CORES-1:0]               wr_hit,
    output logic [NUM_CORES-1:0]               wr_stall
);

    localparam int unsigned CORE_W = $clog2(NUM_CORES);
    localparam int unsigned CHAN_W = $clog2(NUM_CHAN);
    localparam int unsigned SLOT_W = $clog2(MAP_DEPTH);
    localparam int unsigned ENTS   = NUM_CORES * MAP_DEPTH;

    logic [NUM_CORES*CHAN_W-1:0]  rd_chan_all, wr_chan_all;
    logic [ENTS-1:0]              map_valid_all;
    logic [ENTS-1:0]              map_dir_all;
    logic [ENTS*REG_NUM_W-1:0]    map_reg_all;
    logic [ENTS*CHAN_W-1:0]       map_chan_all;
    logic [NUM_CORES-1:0]         rd_ok, wr_ok;
    logic [NUM_CHAN-1:0]          chan_full;

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
        logic core_cfg_we;
        assign core_cfg_we = cfg_we && (cfg_core == CORE_W'(k));

        regch_map_table #(
            .MAP_DEPTH (MAP_DEPTH),
            .CHAN_W    (CHAN_W),
            .SLOT_W    (SLOT_W)
        ) u_tab (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (core_cfg_we),
            .cfg_slot  (cfg_slot),
            .cfg_valid (cfg_valid),
            .cfg_dir   (cfg_dir),
            .cfg_reg   (cfg_reg),
            .cfg_chan  (cfg_chan),
            .ent_valid (map_valid_all[k*MAP_DEPTH +: MAP_DEPTH]),
            .ent_dir   (map_dir_all[k*MAP_DEPTH +: MAP_DEPTH]),
            .ent_reg   (map_reg_all[k*MAP_DEPTH*REG_NUM_W +: MAP_DEPTH*REG_NUM_W]),
            .ent_chan  (map_chan_all[k*MAP_DEPTH*CHAN_W +: MAP_DEPTH*CHAN_W])
        );

        regch_lookup #(
            .MAP_DEPTH (MAP_DEPTH),
            .CHAN_W    (CHAN_W),
            .WANT_DIR  (1'b0)
        ) u_rd_look (
            .ent_valid (map_valid_all[k*MAP_DEPTH +: MAP_DEPTH]),
            .ent_dir   (map_dir_all[k*MAP_DEPTH +: MAP_DEPTH]),
            .ent_reg   (map_reg_all[k*MAP_DEPTH*REG_NUM_W +: MAP_DEPTH*REG_NUM_W]),
            .ent_chan  (map_chan_all[k*MAP_DEPTH*CHAN_W +: MAP_DEPTH*CHAN_W]),
            .req       (rd_req[k]),
            .rnum      (rd_reg[k*REG_NUM_W +: REG_NUM_W]),
            .hit       (rd_hit[k]),
            .chan      (rd_chan_all[k*CHAN_W +: CHAN_W])
        );

        regch_lookup #(
            .MAP_DEPTH (MAP_DEPTH),
            .CHAN_W    (CHAN_W),
            .WANT_DIR  (1'b1)
        ) u_wr_look (
            .ent_valid (map_valid_all[k*MAP_DEPTH +: MAP_DEPTH]),
            .ent_dir   (map_dir_all[k*MAP_DEPTH +: MAP_DEPTH]),
            .ent_reg   (map_reg_all[k*MAP_DEPTH*REG_NUM_W +: MAP_DEPTH*REG_NUM_W]),
            .ent_chan  (map_chan_all[k*MAP_DEPTH*CHAN_W +: MAP_DEPTH*CHAN_W]),
            .req       (wr_req[k]),
            .rnum      (wr_reg[k*REG_NUM_W +: REG_NUM_W]),
            .hit       (wr_hit[k]),
            .chan      (wr_chan_all[k*CHAN_W +: CHAN_W])
        );
    end

    regch_chan_bank #(
        .NUM_CORES (NUM_CORES),
        .NUM_CHAN  (NUM_CHAN),
        .DATA_W    (DATA_W),
        .CHAN_W    (CHAN_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_hit    (rd_hit),
        .rd_chan   (rd_chan_all),
        .wr_hit    (wr_hit),
        .wr_chan   (wr_chan_all),
        .wr_data   (wr_data),
        .rd_ok     (rd_ok),
        .rd_word   (rd_data),
        .wr_ok     (wr_ok),
        .chan_full (chan_full)
    );

    assign rd_stall = rd_hit & ~rd_ok;
    assign wr_stall = wr_hit & ~wr_ok;

endmodule

// File: rtl/regch_fabric_chk.sv
module regch_fabric_chk #(
    parameter int unsigned NUM_CORES = 8,
    parameter int unsigned NUM_CHAN  = 16,
    parameter int unsigned MAP_DEPTH = 4
) (
    input logic                                          clk,
    input logic                                          rst_n,
    input logic [NUM_CORES-1:0]                          rd_hit,
    input logic [NUM_CORES-1:0]                          rd_stall,
    input logic [NUM_CORES-1:0]                          wr_hit,
    input logic [NUM_CORES-1:0]                          wr_stall,
    input logic [NUM_CORES*$clog2(NUM_CHAN)-1:0]         rd_chan_all,
    input logic [NUM_CHAN-1:0]                           chan_full,
    input logic [NUM_CORES*MAP_DEPTH-1:0]                map_valid_all,
    input logic [NUM_CORES*MAP_DEPTH*5-1:0]              map_reg_all
);

    localparam int unsigned CHAN_W = $clog2(NUM_CHAN);

    AST_STALL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stall & ~rd_hit) == '0) && ((wr_stall & ~wr_hit) == '0)); // R4

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core_chk
        AST_EMPTY_READ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hit[i] && !chan_full[rd_chan_all[i*CHAN_W +: CHAN_W]]) |-> rd_stall[i]); // R2
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan_chk
        AST_FILL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chan_full[c]) |-> $past(|(wr_hit & ~wr_stall))); // R7
        AST_DRAIN_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(chan_full[c]) |-> $past(|(rd_hit & ~rd_stall))); // R1
    end

    for (genvar e = 0; e < NUM_CORES*MAP_DEPTH; e++) begin : g_ent_chk
        AST_NO_REG0_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            map_valid_all[e] |-> (map_reg_all[e*5 +: 5] != 5'd0)); // R6
    end

endmodule

bind regch_fabric regch_fabric_chk #(
    .NUM_CORES (NUM_CORES),
    .NUM_CHAN  (NUM_CHAN),
    .MAP_DEPTH (MAP_DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_hit        (rd_hit),
    .rd_stall      (rd_stall),
    .wr_hit        (wr_hit),
    .wr_stall      (wr_stall),
    .rd_chan_all   (rd_chan_all),
    .chan_full     (chan_full),
    .map_valid_all (map_valid_all),
    .map_reg_all   (map_reg_all)
);

// File: tb/regch_fabric_bench.sv
`timescale 1ns/1ps
module regch_fabric_bench;

    localparam int NC = 8;
    localparam int NH = 16;
    localparam int DW = 32;
    localparam int MD = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_core = '0;
    logic [1:0]        cfg_slot = '0;
    logic              cfg_valid = 1'b0;
    logic              cfg_dir = 1'b0;
    logic [4:0]        cfg_reg = '0;
    logic [3:0]        cfg_chan = '0;
    logic [NC-1:0]     rd_req = '0;
    logic [NC*5-1:0]   rd_reg = '0;
    logic [NC-1:0]     rd_hit, rd_stall;
    logic [NC*DW-1:0]  rd_data;
    logic [NC-1:0]     wr_req = '0;
    logic [NC*5-1:0]   wr_reg = '0;
    logic [NC*DW-1:0]  wr_data = '0;
    logic [NC-1:0]     wr_hit, wr_stall;

    regch_fabric u_regch_fabric (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_core(cfg_core),
        .cfg_slot(cfg_slot), .cfg_valid(cfg_valid), .cfg_dir(cfg_dir),
        .cfg_reg(cfg_reg), .cfg_chan(cfg_chan), .rd_req(rd_req),
        .rd_reg(rd_reg), .rd_hit(rd_hit), .rd_stall(rd_stall),
        .rd_data(rd_data), .wr_req(wr_req), .wr_reg(wr_reg),
        .wr_data(wr_data), .wr_hit(wr_hit), .wr_stall(wr_stall)
    );

    always #10 clk = ~clk;  // 50 MHz

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of mapping tables and channels
    bit          m_v [NC][MD];
    bit          m_d [NC][MD];
    int          m_r [NC][MD];
    int          m_c [NC][MD];
    bit          ch_full [NH];
    logic [31:0] ch_data [NH];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_req();
        rd_req = '0; wr_req = '0; rd_reg = '0; wr_reg = '0; wr_data = '0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NC; i++)
            for (int s = 0; s < MD; s++) begin
                m_v[i][s] = 0; m_d[i][s] = 0; m_r[i][s] = 0; m_c[i][s] = 0;
            end
        for (int c = 0; c < NH; c++) begin
            ch_full[c] = 0; ch_data[c] = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_req();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic cfg(input int core, input int slot, input bit valid,
                       input bit dir, input int rnum, input int chan);
        @(negedge clk);
        clear_req();
        cfg_we = 1'b1; cfg_core = 3'(core); cfg_slot = 2'(slot);
        cfg_valid = valid; cfg_dir = dir; cfg_reg = 5'(rnum); cfg_chan = 4'(chan);
        if (!(valid && rnum == 0)) begin
            m_v[core][slot] = valid; m_d[core][slot] = dir;
            m_r[core][slot] = rnum;  m_c[core][slot] = chan;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int core, input int rnum);
        rd_req[core] = 1'b1; rd_reg[core*5 +: 5] = 5'(rnum);
    endtask

    task automatic wr(input int core, input int rnum, input logic [31:0] d);
        wr_req[core] = 1'b1; wr_reg[core*5 +: 5] = 5'(rnum); wr_data[core*DW +: DW] = d;
    endtask

    function automatic int lk(input int core, input int rnum, input bit dir);
        for (int s = 0; s < MD; s++)
            if (m_v[core][s] && m_d[core][s] == dir && m_r[core][s] == rnum) return m_c[core][s];
        return -1;
    endfunction

    // One random cycle: compare against the model, then advance the model
    task automatic model_step();
        int rc[NC]; int wc[NC];
        int rwin[NH]; int wwin[NH];
        bit racc[NH]; bit wacc[NH];
        bit es; logic [31:0] ed;
        for (int i = 0; i < NC; i++) begin
            rc[i] = rd_req[i] ? lk(i, int'(rd_reg[i*5 +: 5]), 1'b0) : -1;
            wc[i] = wr_req[i] ? lk(i, int'(wr_reg[i*5 +: 5]), 1'b1) : -1;
        end
        for (int c = 0; c < NH; c++) begin
            rwin[c] = -1; wwin[c] = -1;
            for (int i = NC - 1; i >= 0; i--) begin
                if (rc[i] == c) rwin[c] = i;
                if (wc[i] == c) wwin[c] = i;
            end
            racc[c] = (rwin[c] >= 0) && ch_full[c];
            wacc[c] = (wwin[c] >= 0) && (!ch_full[c] || racc[c]);
        end
        for (int i = 0; i < NC; i++) begin
            chk("R4/R9 rd_hit", 32'(rd_hit[i]), 32'(rc[i] >= 0));
            chk("R4/R9 wr_hit", 32'(wr_hit[i]), 32'(wc[i] >= 0));
            es = (rc[i] >= 0) && !(racc[rc[i]] && rwin[rc[i]] == i);
            chk("R2/R8 rd_stall", 32'(rd_stall[i]), 32'(es));
            ed = ((rc[i] >= 0) && !es) ? ch_data[rc[i]] : 32'h0;
            chk("R1/R5 rd_data", rd_data[i*DW +: DW], ed);
            es = (wc[i] >= 0) && !(wacc[wc[i]] && wwin[wc[i]] == i);
            chk("R3/R8 wr_stall", 32'(wr_stall[i]), 32'(es));
        end
        for (int c = 0; c < NH; c++) begin
            if (wacc[c]) begin
                ch_full[c] = 1; ch_data[c] = wr_data[wwin[c]*DW +: DW];
            end else if (racc[c]) begin
                ch_full[c] = 0;
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5eed_0042);
        do_reset();

        // R10: reset state, nothing mapped
        @(negedge clk);
        for (int i = 0; i < NC; i++) rd(i, 12);
        for (int i = 0; i < NC; i++) wr(i, 12, 32'hdead0000 + i);
        #2;
        chk("R10 rd_hit after reset", 32'(rd_hit), 32'h0);
        chk("R10 wr_hit after reset", 32'(wr_hit), 32'h0);
        chk("R4 no stall unmapped", 32'(rd_stall | wr_stall), 32'h0);
        chk("R4 rd_data zero", rd_data[7*DW +: DW], 32'h0);

        // Channel 3: core 7 reg 12 source, core 2 reg 10 sink
        cfg(7, 0, 1, 1, 12, 3);
        cfg(2, 0, 1, 0, 10, 3);

        @(negedge clk); clear_req(); rd(2, 10); #2;
        chk("R2 empty read hit", 32'(rd_hit[2]), 32'h1);
        chk("R2 empty read stall", 32'(rd_stall[2]), 32'h1);

        @(negedge clk); clear_req(); rd(2, 10); wr(7, 12, 32'haaaa0001); #2;
        chk("R7 write on empty accepted", 32'(wr_stall[7]), 32'h0);
        chk("R7 reader stalls same cycle", 32'(rd_stall[2]), 32'h1);

        @(negedge clk); clear_req(); rd(2, 10); wr(7, 12, 32'hbbbb0002); #2;
        chk("R1 read of full no stall", 32'(rd_stall[2]), 32'h0);
        chk("R1 read data", rd_data[2*DW +: DW], 32'haaaa0001);
        chk("R5 write with drain accepted", 32'(wr_stall[7]), 32'h0);

        @(negedge clk); clear_req(); wr(7, 12, 32'hcccc0003); #2;
        chk("R3 write on full stalls", 32'(wr_stall[7]), 32'h1);

        @(negedge clk); clear_req(); rd(2, 10); #2;
        chk("R5/R3 kept word", rd_data[2*DW +: DW], 32'hbbbb0002);
        chk("R5 read no stall", 32'(rd_stall[2]), 32'h0);

        @(negedge clk); clear_req(); rd(2, 10); #2;
        chk("R1 emptied after read", 32'(rd_stall[2]), 32'h1);

        // R6: register 0 cannot be mapped
        cfg(1, 0, 1, 0, 0, 5);
        cfg(1, 1, 1, 0, 4, 5);
        cfg(1, 1, 1, 0, 0, 5);
        @(negedge clk); clear_req(); rd(1, 0); #2;
        chk("R6 reg0 never hits", 32'(rd_hit[1]), 32'h0);
        @(negedge clk); clear_req(); rd(1, 4); #2;
        chk("R6 entry kept after reg0 write", 32'(rd_hit[1]), 32'h1);
        chk("R6 kept entry empty chan stall", 32'(rd_stall[1]), 32'h1);

        // R9: direction must match; invalidation
        @(negedge clk); clear_req(); wr(1, 4, 32'h1); #2;
        chk("R9 sink entry ignores write", 32'(wr_hit[1]), 32'h0);
        chk("R9 no stall on dir mismatch", 32'(wr_stall[1]), 32'h0);
        cfg(1, 1, 0, 0, 4, 5);
        @(negedge clk); clear_req(); rd(1, 4); #2;
        chk("R9 invalidated entry", 32'(rd_hit[1]), 32'h0);

        // R8: contention on channel 6
        cfg(0, 0, 1, 1, 5, 6);
        cfg(4, 0, 1, 1, 5, 6);
        cfg(6, 0, 1, 0, 7, 6);
        cfg(3, 0, 1, 0, 7, 6);
        @(negedge clk); clear_req(); wr(0, 5, 32'h00000a0a); wr(4, 5, 32'h00000b0b); #2;
        chk("R8 low writer wins", 32'(wr_stall[0]), 32'h0);
        chk("R8 high writer stalls", 32'(wr_stall[4]), 32'h1);
        @(negedge clk); clear_req(); rd(3, 7); rd(6, 7); #2;
        chk("R8 low reader wins", 32'(rd_stall[3]), 32'h0);
        chk("R8 winner data", rd_data[3*DW +: DW], 32'h00000a0a);
        chk("R8 high reader stalls", 32'(rd_stall[6]), 32'h1);

        // Random phase on a fresh configuration
        do_reset();
        for (int c = 0; c < 8; c++) begin
            cfg(c, 0, 1, 1, c + 1, c);
            cfg((c + 3) % 8, 1, 1, 0, c + 9, c);
        end
        cfg(1, 2, 1, 1, 20, 8);
        cfg(5, 2, 1, 1, 20, 8);
        cfg(2, 3, 1, 0, 21, 8);
        cfg(6, 3, 1, 0, 21, 8);

        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            clear_req();
            for (int i = 0; i < NC; i++) begin
                int rr; int wrn;
                rr  = ($urandom_range(0, 3) != 0) ? (((i + 5) % 8) + 9) : int'($urandom_range(0, 31));
                if ((i == 2 || i == 6) && $urandom_range(0, 1) == 1) rr = 21;
                wrn = ($urandom_range(0, 3) != 0) ? (i + 1) : int'($urandom_range(0, 31));
                if ((i == 1 || i == 5) && $urandom_range(0, 1) == 1) wrn = 20;
                if ($urandom_range(0, 1) == 1) rd(i, rr);
                if ($urandom_range(0, 1) == 1) wr(i, wrn, $urandom());
            end
            #2;
            model_step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule